// File: doc/BRIEF.md
# Scan-Input Interleaving Stage

This block sits between the M outputs of an upstream reconfigurable connection network and the M serial inputs of a set of scan chains. Its purpose is to break up test cubes whose specified bits are bunched into one chain. It scatters those bits over many chains, and it does so without reordering any scan cell inside the chains.

Each chain input is driven by its own M-input multiplexer. Input j of the multiplexer that feeds chain i is wired to source (i + j) mod M. One shared selection index drives every multiplexer. The index is 0 on the first shift cycle of a pattern, rises by one on every shift cycle, and returns to 0 after M-1. The effect is that the vertical slice of cells loaded at shift position k is the source slice rotated by k mod M.

The data path is combinational and moves in lock-step with the scan shift clock. There is no valid/ready handshake and no back-pressure. Every cycle with `shift_en` high consumes one source slice and delivers one chain slice. Stalling the shift is done by lowering `shift_en`, which freezes the index. The only stored state is the modulo-M counter.

Top module: `scan_interleave`

## Requirements
- R1: After reset the selection index is 0. With `pat_start` low, the first shifted slice passes straight through: chain i receives source i.
- R2: When the index in use is k, output bit i equals source bit (i + k) mod M, for every i. That is, the output is the source rotated right by k.
- R3: Each cycle with `shift_en` high and `pat_start` low advances the index by one for the next cycle.
- R4: Once the index M-1 has been used in a shift cycle, the next index is 0.
- R5: While `shift_en` is low and `pat_start` is low (capture or idle), the index holds its value.
- R6: In a cycle with `pat_start` high, the index in use is 0, whatever the counter holds. If `shift_en` is also high, the next index is 1 mod M.
- R7: `pat_start` high with `shift_en` low leaves the next index at 0.
- R8: In every cycle the output is a permutation of the source: the number of ones is the same on both buses.
- R9: Take a slice stream that starts with `pat_start` and holds a single set source bit for M shift cycles. Each chain receives that bit in exactly one of those cycles, and exactly one chain receives it in each cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | High in cycles where a slice is shifted into the chains |
| pat_start | input | 1 | Marks the first cycle of a new pattern's load |
| src_bits | input | M | Slice from the reconfiguration network, bit i is its output i |
| chain_bits | output | M | Slice delivered to the scan chain inputs, bit i feeds chain i |

## Verification
The collision that matters is the pattern-start strobe landing in a shift cycle while the counter sits mid-count. The override must supply index 0 to the multiplexers in that same cycle, and it must also let the counter step to 1, not to its old value plus one. The stimulus table provokes this after several shifts, and then again with the strobe in a non-shift cycle. In each case the bench judges the current slice by the rotation by 0, and the following slices by rotations by 1 and 0 respectively. Wrap at M-1, holding during capture and single-bit scattering over a full period are checked the same way, against a rotation computed in the bench.

// File: rtl/scil_pkg.sv
package scil_pkg;

  // Width of an index that can address m positions, never below one bit.
  function automatic int idx_width(input int m);
    int w;
    w = 1;
    while ((1 << w) < m) w++;
    return w;
  endfunction

  // Source position feeding input j of the lane that drives chain lane.
  function automatic int src_of(input int lane, input int j, input int m);
    return (lane + j) % m;
  endfunction

endpackage

// File: rtl/scil_sel_counter.sv
module scil_sel_counter
  import scil_pkg::*;
#(
  parameter int M  = 8,
  parameter int CW = idx_width(M)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         pat_start,
  output logic [CW-1:0] sel_idx,
  output logic [M-1:0]  sel_oh
);

  localparam logic [CW-1:0] LAST  = CW'(M - 1);
  localparam logic [CW-1:0] AFTER = CW'(1 % M);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // Index in use this cycle: a pattern start forces position 0.
  always_comb begin
    sel_idx = pat_start ? '0 : cnt_q;
  end

  always_comb begin
    if (pat_start) begin
      cnt_d = shift_en ? AFTER : '0;
    end else if (shift_en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Fully decoded select for the lane multiplexers.
  always_comb begin
    for (int j = 0; j < M; j++) begin
      sel_oh[j] = (sel_idx == CW'(j));
    end
  end

  // R3: one step forward per plain shift cycle
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !pat_start && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4: wrap after the last index
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !pat_start && cnt_q == LAST) |=> (cnt_q == '0));

  // R5: hold during capture
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !pat_start) |=> $stable(cnt_q));

  // R6: start strobe in a shift cycle leaves index one behind it
  a_r6_start_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_start && shift_en) |=> (cnt_q == AFTER));

  // R7: start strobe without shift parks the index at 0
  a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_start && !shift_en) |=> (cnt_q == '0));

  // R2: exactly one lane input selected and the index in range
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sel_oh) == 1) && (cnt_q <= LAST));

endmodule

// File: rtl/scil_lane.sv
module scil_lane
  import scil_pkg::*;
#(
  parameter int M    = 8,
  parameter int LANE = 0
) (
  input  logic [M-1:0] src_bits,
  input  logic [M-1:0] sel_oh,
  output logic         chain_bit
);

  logic [M-1:0] wired;

  // Rotated wiring: input j of this lane comes from source (LANE + j) mod M.
  for (genvar j = 0; j < M; j++) begin : g_in
    assign wired[j] = src_bits[src_of(LANE, j, M)];
  end

  // AND-OR multiplexer over the one-hot select.
  assign chain_bit = |(wired & sel_oh);

endmodule

// File: rtl/scan_interleave.sv
module scan_interleave
  import scil_pkg::*;
#(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         pat_start,
  input  logic [M-1:0] src_bits,
  output logic [M-1:0] chain_bits
);

  localparam int CW = idx_width(M);

  logic [CW-1:0] sel_idx;
  logic [M-1:0]  sel_oh;

  scil_sel_counter #(.M(M), .CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .pat_start (pat_start),
    .sel_idx   (sel_idx),
    .sel_oh    (sel_oh)
  );

  for (genvar i = 0; i < M; i++) begin : g_lane
    scil_lane #(.M(M), .LANE(i)) u_lane (
      .src_bits  (src_bits),
      .sel_oh    (sel_oh),
      .chain_bit (chain_bits[i])
    );
  end

  // R8: the stage only permutes bits, never creates or drops them
  a_r8_permute: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chain_bits) == $countones(src_bits));

  // R6: during a start strobe the slice passes unrotated
  a_r6_start_passes: assert property (@(posedge clk) disable iff (!rst_n)
    pat_start |-> (chain_bits == src_bits));

endmodule

// File: tb/scan_interleave_test.sv
module scan_interleave_test;

  localparam int M = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_en = 1'b0;
  logic         pat_start = 1'b0;
  logic [M-1:0] src_bits = '0;
  logic [M-1:0] chain_bits;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scan_interleave #(.M(M)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .pat_start  (pat_start),
    .src_bits   (src_bits),
    .chain_bits (chain_bits)
  );

  // Expected slice: chain i gets source (i + k) mod M.
  function automatic logic [M-1:0] rot(input logic [M-1:0] s, input int k);
    logic [M-1:0] r;
    for (int i = 0; i < M; i++) r[i] = s[(i + k) % M];
    return r;
  endfunction

  task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Row: pat_start, shift_en, src, index expected in this cycle
  typedef struct packed {
    logic       ps;
    logic       sh;
    logic [7:0] src;
    logic [3:0] k;
  } row_t;

  localparam row_t TBL [16] = '{
    '{1'b0, 1'b1, 8'hA5, 4'd0},  // R1 first slice unrotated
    '{1'b0, 1'b1, 8'h3C, 4'd1},  // R3
    '{1'b0, 1'b0, 8'h81, 4'd2},  // R5 capture
    '{1'b0, 1'b0, 8'h0F, 4'd2},  // R5 still held
    '{1'b0, 1'b1, 8'hF0, 4'd2},  // R2
    '{1'b0, 1'b1, 8'h96, 4'd3},
    '{1'b0, 1'b1, 8'h01, 4'd4},
    '{1'b0, 1'b1, 8'hC3, 4'd5},
    '{1'b0, 1'b1, 8'h5A, 4'd6},
    '{1'b0, 1'b1, 8'h17, 4'd7},  // R4 last index
    '{1'b0, 1'b1, 8'hE8, 4'd0},  // R4 wrapped
    '{1'b1, 1'b1, 8'h6B, 4'd0},  // R6 start mid-count with shift
    '{1'b0, 1'b1, 8'hB2, 4'd1},  // R6 next index 1
    '{1'b1, 1'b0, 8'h4D, 4'd0},  // R7 start without shift
    '{1'b0, 1'b0, 8'h2E, 4'd0},  // R7 parked at 0
    '{1'b0, 1'b1, 8'h9F, 4'd0}   // R7 shift begins at 0
  };

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [M-1:0] seen;
    // R1: reset state, index 0 passes slice straight through
    src_bits = 8'h12;
    repeat (3) @(negedge clk);
    #1 check("R1 reset", chain_bits, 8'h12);
    rst_n = 1'b1;

    // Table walk
    foreach (TBL[n]) begin
      @(negedge clk);
      pat_start = TBL[n].ps;
      shift_en  = TBL[n].sh;
      src_bits  = TBL[n].src;
      #1;
      check($sformatf("R2 row %0d", n), chain_bits, rot(TBL[n].src, int'(TBL[n].k)));
      n_run++;
      if ($countones(chain_bits) != $countones(TBL[n].src)) begin
        n_fail++;
        $display("FAIL R8 row %0d actual=%0d expected=%0d", n,
                 $countones(chain_bits), $countones(TBL[n].src));
      end
    end

    // R9: single set bit scattered over all chains in one period
    seen = '0;
    for (int c = 0; c < M; c++) begin
      @(negedge clk);
      pat_start = (c == 0);
      shift_en  = 1'b1;
      src_bits  = 8'h08;
      #1;
      check($sformatf("R9 cycle %0d", c), chain_bits, rot(8'h08, c));
      seen |= chain_bits;
    end
    check("R9 coverage", seen, 8'hFF);

    // R1: reset in mid-count returns the index to 0
    @(negedge clk);
    pat_start = 1'b0;
    shift_en  = 1'b1;
    src_bits  = 8'hD4;
    #1 check("R3 mid-count", chain_bits, rot(8'hD4, 0));
    @(negedge clk);
    #1 check("R3 step", chain_bits, rot(8'hD4, 1));
    rst_n = 1'b0;
    #1 check("R1 reset mid-count", chain_bits, 8'hD4);
    @(negedge clk);
    rst_n = 1'b1;
    src_bits = 8'h39;
    #1 check("R1 after reset", chain_bits, 8'h39);
    @(negedge clk);
    shift_en = 1'b0;
    #1 check("R3 after reset", chain_bits, rot(8'h39, 1));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule